// File: doc/BRIEF.md
# Linear Compressed Page Address Unit

This unit turns a request for one 64-byte line of a compressed 4 KB page into the physical address that holds that line. All 64 lines of a page occupy slots of one size. The slot size follows from a two-bit size code carried with the request, which gives physical pages of 4 KB, 2 KB, 1 KB or 512 B. A line that fits its slot lives at the page base plus the line index times the slot size.

Each compressed page also has a metadata region and an exception region, both placed after the 64 slots. For every line, the metadata tells whether the line is all zero, and whether it overflowed into the exception region and at which exception index. A small direct-mapped cache keeps whole-page metadata records. On a miss the unit issues one metadata fetch, fills the cache entry and then replays the translation. Requests for zero pages, and for lines marked zero, complete with a zero flag and no data address.

Top module: `lcp_xlate`

## Requirements
- R1: After reset, `rsp_valid` and `md_req_valid` are low and `req_ready` is high.
- R2: Size code 0, 1, 2 or 3 selects a slot of 64, 32, 16 or 8 bytes. On a metadata hit, a line that is neither zero nor an exception responds in the cycle after acceptance with `rsp_addr` = `req_pbase` + line × slot, and both flags low.
- R3: A request with `req_zpage` high responds in the next cycle with `rsp_zero` high and `rsp_addr` zero. It issues no metadata fetch and does not consult the cache.
- R4: The metadata record for line i sits at bits [i×5 +: 5] of the page metadata word. Bit 0 is the zero flag, bit 1 is the exception flag and bits 4:2 are the exception index. A line with the zero flag set responds with `rsp_zero` high, `rsp_exc` low and `rsp_addr` zero.
- R5: A line with the exception flag set and the zero flag clear responds with `rsp_exc` high at `rsp_addr` = `req_pbase` + 64 × slot + 64 + index × 64.
- R6: On a metadata miss, `md_req_valid` rises in the cycle after acceptance with `md_req_addr` = `req_pbase` + 64 × slot. Both stay steady until `md_rsp_valid`, and `req_ready` stays low for that time.
- R7: After `md_rsp_valid` is sampled, the filled record is used, and the response appears two cycles after that edge.
- R8: The cache has 4 entries indexed by page number modulo 4 and tagged with the full page number. A later request to a cached page hits with no fetch. A different page that maps to the same entry evicts it, so a return to the first page misses again.
- R9: While `req_ready` is low, `req_valid` is ignored: no extra response appears and the pending translation is not altered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Unit can accept a request |
| req_page | input | 20 | Page number, used as cache tag |
| req_line | input | 6 | Line index in the page |
| req_pbase | input | 32 | Physical base of the compressed page |
| req_size | input | 2 | Slot size code |
| req_zpage | input | 1 | Page is entirely zero |
| md_req_valid | output | 1 | Metadata fetch pending |
| md_req_addr | output | 32 | Address of the metadata region |
| md_rsp_valid | input | 1 | Metadata word delivered |
| md_rsp_data | input | 320 | Page metadata, 5 bits per line |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_addr | output | 32 | Physical line address, zero when the line is zero |
| rsp_zero | output | 1 | Line reads as zero, no data access needed |
| rsp_exc | output | 1 | Line is held in the exception region |

## Verification
The bench uses the default configuration: 32-bit addresses, 64 lines, a 3-bit exception index and four cache entries. With only four entries, the sweep touches eight pages under every size code, so every line of every page is translated and evictions through shared entries happen naturally. The metadata pattern is derived from page and line numbers, so zero lines, exception lines at all eight indices and plain lines all appear under every slot size. Stray requests during each fetch, and zero-page requests between sweeps, exercise the paths that must leave the cache and the outputs untouched.

// File: rtl/lcp_xlate.sv
module lcp_xlate #(
  parameter int ADDR_W   = 32,
  parameter int PAGE_W   = 20,
  parameter int LINES    = 64,
  parameter int EXC_W    = 3,
  parameter int SETS     = 4,
  parameter int MD_BYTES = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [PAGE_W-1:0]           req_page,
  input  logic [$clog2(LINES)-1:0]    req_line,
  input  logic [ADDR_W-1:0]           req_pbase,
  input  logic [1:0]                  req_size,
  input  logic                        req_zpage,
  output logic                        md_req_valid,
  output logic [ADDR_W-1:0]           md_req_addr,
  input  logic                        md_rsp_valid,
  input  logic [LINES*(EXC_W+2)-1:0]  md_rsp_data,
  output logic                        rsp_valid,
  output logic [ADDR_W-1:0]           rsp_addr,
  output logic                        rsp_zero,
  output logic                        rsp_exc
);
  localparam int LINE_W = $clog2(LINES);
  localparam int SET_W  = $clog2(SETS);
  localparam int REC_W  = EXC_W + 2;
  localparam int MD_W   = LINES * REC_W;

  typedef enum logic [1:0] {IDLE, FETCH, REPLAY} st_t;
  st_t st;

  logic [PAGE_W-1:0] l_page;
  logic [LINE_W-1:0] l_line;
  logic [ADDR_W-1:0] l_pbase;
  logic [1:0]        l_size;

  logic [PAGE_W-1:0] tag_q [SETS];
  logic [MD_W-1:0]   md_q  [SETS];
  logic [SETS-1:0]   vld_q;

  wire               use_in  = (st == IDLE);
  wire [PAGE_W-1:0]  s_page  = use_in ? req_page  : l_page;
  wire [LINE_W-1:0]  s_line  = use_in ? req_line  : l_line;
  wire [ADDR_W-1:0]  s_pbase = use_in ? req_pbase : l_pbase;
  wire [1:0]         s_size  = use_in ? req_size  : l_size;
  wire               s_zpg   = use_in & req_zpage;

  wire [SET_W-1:0]   set     = s_page[SET_W-1:0];
  wire               hit     = vld_q[set] && (tag_q[set] == s_page);
  wire [REC_W-1:0]   rec     = md_q[set][s_line*REC_W +: REC_W];
  wire [2:0]         sh      = 3'd6 - {1'b0, s_size};

  wire [ADDR_W-1:0]  line_off = ADDR_W'(s_line) << sh;
  wire [ADDR_W-1:0]  md_base  = s_pbase + (ADDR_W'(LINES) << sh);
  wire [ADDR_W-1:0]  exc_addr = md_base + ADDR_W'(MD_BYTES) + (ADDR_W'(rec[2 +: EXC_W]) << 6);

  wire               r_zero  = s_zpg | rec[0];
  wire               r_exc   = ~r_zero & rec[1];
  wire [ADDR_W-1:0]  r_addr  = r_zero ? '0 : (r_exc ? exc_addr : s_pbase + line_off);

  assign req_ready    = (st == IDLE);
  assign md_req_valid = (st == FETCH);
  assign md_req_addr  = md_base;

  wire accept  = req_valid & req_ready;
  wire respond = (accept & (req_zpage | hit)) | (st == REPLAY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= IDLE;
      vld_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
      rsp_zero  <= 1'b0;
      rsp_exc   <= 1'b0;
    end else begin
      rsp_valid <= respond;
      if (respond) begin
        rsp_addr <= r_addr;
        rsp_zero <= r_zero;
        rsp_exc  <= r_exc;
      end
      case (st)
        IDLE:   if (accept && !req_zpage && !hit) st <= FETCH;
        FETCH:  if (md_rsp_valid) begin
                  st <= REPLAY;
                  vld_q[l_page[SET_W-1:0]] <= 1'b1;
                end
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      l_page  <= req_page;
      l_line  <= req_line;
      l_pbase <= req_pbase;
      l_size  <= req_size;
    end
    if (st == FETCH && md_rsp_valid) begin
      tag_q[l_page[SET_W-1:0]] <= l_page;
      md_q[l_page[SET_W-1:0]]  <= md_rsp_data;
    end
  end

  // R3
  zpage_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_zpage |=> rsp_valid && rsp_zero && rsp_addr == '0 && !md_req_valid);
  // R4
  zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_zero |-> rsp_addr == '0 && !rsp_exc);
  // R6
  md_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    md_req_valid && !md_rsp_valid |=> md_req_valid && $stable(md_req_addr) && !req_ready);
  // R7
  replay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    md_req_valid && md_rsp_valid |=> !rsp_valid ##1 rsp_valid);
endmodule

// File: tb/lcp_xlate_test.sv
module lcp_xlate_test;
  logic         clk = 0;
  logic         rst_n = 0;
  logic         req_valid = 0;
  logic         req_ready;
  logic [19:0]  req_page = 0;
  logic [5:0]   req_line = 0;
  logic [31:0]  req_pbase = 0;
  logic [1:0]   req_size = 0;
  logic         req_zpage = 0;
  logic         md_req_valid;
  logic [31:0]  md_req_addr;
  logic         md_rsp_valid = 0;
  logic [319:0] md_rsp_data = 0;
  logic         rsp_valid;
  logic [31:0]  rsp_addr;
  logic         rsp_zero;
  logic         rsp_exc;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  logic [19:0] btag [4];
  logic [3:0]  bvld = 0;

  always #10 clk = ~clk;

  lcp_xlate uut (.*);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: run hung, act=%0d exp<150000 cycles", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", r, act, exp);
    end
  endtask

  function automatic logic [319:0] mkmd(input int p);
    logic [319:0] d = '0;
    for (int l = 0; l < 64; l++) begin
      logic z = (l % 7) == 3;
      logic e = !z && ((l % 5) == 1);
      d[l*5 +: 5] = {3'((l + p) % 8), e, z};
    end
    return d;
  endfunction

  function automatic logic [31:0] pb(input int p);
    return 32'h1000_0000 + 32'(p) * 32'h1000;
  endfunction

  task automatic xlate(input int p, input int l, input int sz, input logic zp);
    int sh = 6 - sz;
    logic z = (l % 7) == 3;
    logic e = !z && ((l % 5) == 1);
    logic [31:0] expa;
    logic miss;
    @(negedge clk);
    req_valid = 1; req_page = 20'(p); req_line = 6'(l);
    req_pbase = pb(p); req_size = 2'(sz); req_zpage = zp;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    miss = !zp && !(bvld[p % 4] && btag[p % 4] == 20'(p));
    if (zp) begin z = 1; e = 0; end
    expa = z ? 32'h0 : e ? pb(p) + (32'd64 << sh) + 32'd64 + 32'((l + p) % 8) * 64
                         : pb(p) + (32'(l) << sh);
    if (miss) begin
      chk("R6 md_req_valid", {31'b0, md_req_valid}, 1);
      chk("R6 md_req_addr", md_req_addr, pb(p) + (32'd64 << sh));
      chk("R6 req_ready low", {31'b0, req_ready}, 0);
      req_valid = 1; req_page = 20'(p ^ 1); req_line = 6'(l ^ 5); req_zpage = 1;
      @(posedge clk);
      @(negedge clk);
      chk("R9 no stray rsp", {31'b0, rsp_valid}, 0);
      chk("R6 md hold", md_req_addr, pb(p) + (32'd64 << sh));
      md_rsp_valid = 1; md_rsp_data = mkmd(p);
      @(posedge clk);
      @(negedge clk);
      md_rsp_valid = 0; req_valid = 0; req_zpage = 0;
      chk("R7 no rsp during replay", {31'b0, rsp_valid}, 0);
      bvld[p % 4] = 1; btag[p % 4] = 20'(p);
      @(posedge clk);
      @(negedge clk);
    end else if (!zp) begin
      chk("R8 hit no fetch", {31'b0, md_req_valid}, 0);
    end else begin
      chk("R3 zpage no fetch", {31'b0, md_req_valid}, 0);
    end
    chk(zp ? "R3 valid" : miss ? "R7 valid" : "R2 valid", {31'b0, rsp_valid}, 1);
    chk(zp ? "R3 addr" : z ? "R4 addr" : e ? "R5 addr" : "R2 addr", rsp_addr, expa);
    chk(z ? "R4 zero flag" : "R2 zero flag", {31'b0, rsp_zero}, {31'b0, z});
    chk(e ? "R5 exc flag" : "R2 exc flag", {31'b0, rsp_exc}, {31'b0, e});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 rsp_valid", {31'b0, rsp_valid}, 0);
    chk("R1 md_req_valid", {31'b0, md_req_valid}, 0);
    chk("R1 req_ready", {31'b0, req_ready}, 1);
    rst_n = 1;
    for (int sz = 0; sz < 4; sz++) begin
      xlate(sz + 9, 2, sz, 1);
      for (int p = 0; p < 8; p++)
        for (int l = 0; l < 64; l++)
          xlate(p + sz * 8, l, sz, 0);
    end
    xlate(40, 1, 1, 0);
    xlate(44, 1, 1, 0);
    xlate(40, 6, 1, 0);
    xlate(40, 2, 1, 1);
    xlate(40, 11, 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule